// File: doc/BRIEF.md
# Field-Programmable Sum-of-Products Array

This block is a two-level logic array whose connections are set at run time. A first plane forms product terms. Each term is the AND of a chosen set of literals, where each input is offered both as itself and as its complement. A second plane forms each output as the OR of a chosen set of terms. The outputs follow the inputs combinationally and use the configuration that was committed last.

The default size is 4 inputs, 10 terms and 4 outputs. A build-time switch selects between two styles:
- **Full array:** both planes are programmable, so one term may serve several outputs.
- **Fixed-OR array:** only the AND plane is programmable. Each output owns a private group of terms (4 per output by default, so 16 terms in total), and no term is shared.

A second switch picks the blank state of the connection bits. In the "all made" style, programming breaks the unwanted connections. In the "all open" style, programming makes the wanted ones.

Configuration is loaded serially into a shadow register. A one-cycle commit strobe then copies the shadow into the active connections in a single step. Software can therefore stream a new function in while the old one keeps running.

Top module: `sop_array`

## Requirements
- R1: In full-array mode, out_vec[o] is 1 exactly when at least one term with its OR bit for output o set evaluates to 1. A term evaluates to 1 when it has at least one connected literal and every connected literal is 1.
- R2: Literal l of term t sits at stream position t*2*N_IN + l. Literal 2*i is in_vec[i] and literal 2*i+1 is its complement. Position 0 is the first bit shifted in.
- R3: A term that has both a literal and its complement connected always evaluates to 0.
- R4: A term with no literal connected always evaluates to 0, even when its OR bits are set.
- R5: In full-array mode, the OR bit for output o and term t sits at stream position AND_W + o*NT + t. One term may drive several outputs at once.
- R6: In fixed-OR mode, out_vec[o] is the OR of terms o*TERMS_PER_OUT to o*TERMS_PER_OUT+TERMS_PER_OUT-1. The OR-plane bits in the stream have no effect.
- R7: Each cycle with cfg_shift high shifts cfg_data into the shadow register. After CFG_W shifts, the first bit is at position 0. Shifting does not change the outputs until a commit.
- R8: A cycle with cfg_load high copies the shadow into the active connections at that clock edge. The outputs use the new function from that edge onward.
- R9: A synchronous reset sets the shadow and the active bits to the blank state: all 1 when BLANK_MADE=1, all 0 when BLANK_MADE=0. In both styles, every output is 0 for every input after reset.
- R10: The outputs are combinational in in_vec. A change on in_vec appears on out_vec in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the blank state |
| cfg_shift | input | 1 | Shift one configuration bit into the shadow register |
| cfg_data | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Commit the shadow register to the active connections |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Logic outputs |

## Verification
The bench programs a BCD-to-Gray converter into both array styles and sweeps all 16 input codes against equations written out in the bench.

It also targets the following corner cases:
- **Contradictory term:** a term holding a literal and its complement must stay 0. A design that forgot this would turn a blank "all made" array into an always-true function.
- **Empty term:** a term with no literals must stay 0. A plain AND reduction over an empty mask would drive every connected output high.
- **Shared term:** one term feeding all four outputs must reach every output.
- **Ignored OR bits in fixed mode:** with every stream OR bit set, an array that honoured those bits would merge all the groups.
- **Shift without commit:** the outputs must keep the old function while new bits stream in. A design that wired the shadow straight through would show a half-loaded function.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Number of product terms actually built for a given style.
  function automatic int term_count(input bit fixed_or, input int n_term,
                                    input int n_out, input int per_out);
    return fixed_or ? n_out * per_out : n_term;
  endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int  SH_W  = 8,
  parameter int  ACT_W = 8,
  parameter bit  BLANK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             data_i,
  input  logic             load_i,
  output logic [ACT_W-1:0] active_o
);

  logic [SH_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow   <= {SH_W{BLANK}};
      active_o <= {ACT_W{BLANK}};
    end else begin
      if (shift_i) shadow <= {data_i, shadow[SH_W-1:1]};
      if (load_i)  active_o <= shadow[ACT_W-1:0];
    end
  end

  // R8: a commit copies the shadow as it stood at that edge
  p_commit_copy_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |=> active_o == $past(shadow[ACT_W-1:0]));

  // R7: without a commit the active connections do not move
  p_active_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(active_o));

  // R7: a shifted bit enters at the top of the shadow
  p_shift_entry_r7: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> shadow[SH_W-1] == $past(data_i));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_IN = 4,
  parameter int NT   = 10,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]    in_i,
  input  logic [NT*LIT_W-1:0] and_bits_i,
  output logic [NT-1:0]      term_o
);

  logic [LIT_W-1:0] lits;

  // Literal 2i is the true input, literal 2i+1 its complement (R2)
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_i[i];
    assign lits[2*i+1] = ~in_i[i];
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    logic [LIT_W-1:0] mask;
    assign mask = and_bits_i[t*LIT_W +: LIT_W];

    always_comb begin
      logic val;
      val = |mask;                       // R4: empty term is off
      for (int l = 0; l < LIT_W; l++)
        if (mask[l] && !lits[l]) val = 1'b0;
      term_o[t] = val;
      // R3: a literal paired with its complement forces the term low
      for (int i = 0; i < N_IN; i++)
        if (mask[2*i] && mask[2*i+1])
          p_contra_low_r3: assert (!val);
    end
  end

endmodule

// File: rtl/sop_or_full.sv
module sop_or_full #(
  parameter int N_OUT = 4,
  parameter int NT    = 10
) (
  input  logic [NT-1:0]       term_i,
  input  logic [N_OUT*NT-1:0] or_bits_i,
  output logic [N_OUT-1:0]    out_o
);

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      out_o[o] = 1'b0;
      for (int t = 0; t < NT; t++)
        if (or_bits_i[o*NT + t] && term_i[t]) out_o[o] = 1'b1;
    end
    // R5: with no active term nothing can reach an output
    if (term_i == '0) p_idle_quiet_r5: assert (out_o == '0);
  end

endmodule

// File: rtl/sop_or_fixed.sv
module sop_or_fixed #(
  parameter int N_OUT   = 4,
  parameter int PER_OUT = 4
) (
  input  logic [N_OUT*PER_OUT-1:0] term_i,
  output logic [N_OUT-1:0]         out_o
);

  // R6: each output owns a private, contiguous group of terms
  for (genvar o = 0; o < N_OUT; o++) begin : g_grp
    assign out_o[o] = |term_i[o*PER_OUT +: PER_OUT];
  end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN          = 4,
  parameter int N_TERM        = 10,
  parameter int N_OUT         = 4,
  parameter int TERMS_PER_OUT = 4,
  parameter bit FIXED_OR      = 1'b0,
  parameter bit BLANK_MADE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift,
  input  logic             cfg_data,
  input  logic             cfg_load,
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_OUT-1:0] out_vec
);

  localparam int NT    = sop_pkg::term_count(FIXED_OR, N_TERM, N_OUT, TERMS_PER_OUT);
  localparam int LIT_W = 2 * N_IN;
  localparam int AND_W = NT * LIT_W;
  localparam int OR_W  = N_OUT * NT;
  localparam int CFG_W = AND_W + OR_W;
  localparam int ACT_W = FIXED_OR ? AND_W : CFG_W;

  logic [ACT_W-1:0] act;
  logic [NT-1:0]    terms;

  sop_cfg_store #(.SH_W(CFG_W), .ACT_W(ACT_W), .BLANK(BLANK_MADE)) u_store (
    .clk(clk), .rst(rst), .shift_i(cfg_shift), .data_i(cfg_data),
    .load_i(cfg_load), .active_o(act)
  );

  sop_and_plane #(.N_IN(N_IN), .NT(NT)) u_and (
    .in_i(in_vec), .and_bits_i(act[AND_W-1:0]), .term_o(terms)
  );

  if (FIXED_OR) begin : g_fixed
    sop_or_fixed #(.N_OUT(N_OUT), .PER_OUT(TERMS_PER_OUT)) u_or (
      .term_i(terms), .out_o(out_vec)
    );
  end else begin : g_full
    sop_or_full #(.N_OUT(N_OUT), .NT(NT)) u_or (
      .term_i(terms), .or_bits_i(act[ACT_W-1:AND_W]), .out_o(out_vec)
    );
  end

  // R9: on the first cycle out of reset the blank array is silent
  p_blank_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> out_vec == '0);

endmodule

// File: tb/sop_array_test.sv
`timescale 1ns/1ps
module sop_array_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_data = 1'b0;
  logic sh0 = 1'b0, sh1 = 1'b0, ld0 = 1'b0, ld1 = 1'b0;
  logic [3:0] din = 4'h0;
  logic [3:0] q0, q1;
  logic live = 1'b0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  // uut: full array, blank = all made; uut_fix: fixed OR, blank = all open
  sop_array uut (
    .clk(clk), .rst(rst), .cfg_shift(sh0), .cfg_data(cfg_data),
    .cfg_load(ld0), .in_vec(din), .out_vec(q0)
  );
  sop_array #(.FIXED_OR(1'b1), .BLANK_MADE(1'b0)) uut_fix (
    .clk(clk), .rst(rst), .cfg_shift(sh1), .cfg_data(cfg_data),
    .cfg_load(ld1), .in_vec(din), .out_vec(q1)
  );

  // reference state, behavioural
  logic [191:0] msh [2];
  logic [191:0] mact[2];
  logic [191:0] st;
  logic [3:0] tp[16], tn[16], tor[16];

  function automatic int nterm(int w); return w ? 16 : 10; endfunction
  function automatic int cwid(int w);  return nterm(w) * 8 + nterm(w) * 4; endfunction

  function automatic logic [3:0] model(int w, logic [3:0] x);
    logic [3:0] r = 4'h0;
    int nt = nterm(w);
    for (int t = 0; t < nt; t++) begin
      bit any = 0, ok = 1;
      for (int l = 0; l < 8; l++)
        if (mact[w][t*8 + l]) begin
          any = 1;
          if (((l % 2) == 0 ? x[l/2] : !x[l/2]) == 1'b0) ok = 0;
        end
      if (any && ok)
        for (int o = 0; o < 4; o++)
          if (w == 1 ? (t / 4 == o) : mact[w][nt*8 + o*nt + t]) r[o] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [3:0] gray(logic [3:0] c);
    logic a = c[3], b = c[2], cc = c[1], d = c[0];
    return {a | (b & cc) | (b & d), b & ~cc, b | cc,
            (~a & ~b & ~cc & d) | (b & cc & d) | (a & ~d) | (~b & cc & ~d)};
  endfunction

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk)
    if (live && !rst) begin
      chk("R10 model uut", q0, model(0, din));
      chk("R10 model uut_fix", q1, model(1, din));
    end

  task automatic clear_tbl();
    for (int t = 0; t < 16; t++) begin tp[t] = 0; tn[t] = 0; tor[t] = 0; end
  endtask

  // BCD-to-Gray terms; w=1 places each output's terms in its own group
  task automatic bcd_tbl(int w);
    logic [3:0] p[10] = '{4'h8, 4'h6, 4'h5, 4'h4, 4'h4, 4'h2, 4'h1, 4'h7, 4'h8, 4'h2};
    logic [3:0] n[10] = '{4'h0, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 4'hE, 4'h0, 4'h1, 4'h5};
    int       o[10] = '{3, 3, 3, 2, 1, 1, 0, 0, 0, 0};
    int cnt[4] = '{0, 0, 0, 0};
    clear_tbl();
    for (int k = 0; k < 10; k++) begin
      int s = w ? o[k] * 4 + cnt[o[k]] : k;
      cnt[o[k]]++;
      tp[s] = p[k]; tn[s] = n[k];
      tor[s] = w ? 4'hF : (4'h1 << o[k]);
    end
  endtask

  task automatic build(int w);
    int nt = nterm(w);
    st = '0;
    for (int t = 0; t < nt; t++) begin
      for (int l = 0; l < 8; l++)
        st[t*8 + l] = (l % 2 == 0) ? tp[t][l/2] : tn[t][l/2];
      for (int o = 0; o < 4; o++) st[nt*8 + o*nt + t] = tor[t][o];
    end
  endtask

  task automatic send(int w);
    int n = cwid(w);
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin
      cfg_data = st[k];
      if (w == 1) sh1 = 1'b1; else sh0 = 1'b1;
      @(posedge clk);
      msh[w] = msh[w] >> 1;
      msh[w][n-1] = st[k];
      #1;
    end
    sh0 = 1'b0; sh1 = 1'b0;
  endtask

  task automatic commit(int w);
    @(posedge clk); #1;
    if (w == 1) ld1 = 1'b1; else ld0 = 1'b1;
    @(posedge clk);
    mact[w] = msh[w];
    #1;
    ld0 = 1'b0; ld1 = 1'b0;
  endtask

  task automatic apply(logic [3:0] c);
    @(posedge clk); #1;
    din = c;
    @(negedge clk);
  endtask

  task automatic do_reset();
    live = 1'b0;
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    msh[0] = {192{1'b1}}; mact[0] = {192{1'b1}};
    msh[1] = '0;          mact[1] = '0;
    #1;
    rst = 1'b0;
    live = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R9: blank arrays of both styles are silent
    for (int c = 0; c < 16; c++) begin
      apply(4'(c));
      chk("R9 blank made", q0, 4'h0);
      chk("R9 blank open", q1, 4'h0);
    end

    // R7: stream BCD-to-Gray; nothing changes before commit
    bcd_tbl(0); build(0); send(0);
    bcd_tbl(1); build(1); send(1);
    apply(4'hF);
    chk("R7 no commit uut", q0, 4'h0);
    chk("R7 no commit uut_fix", q1, 4'h0);
    commit(0); commit(1);

    // R1 full array, R6 fixed OR with every stream OR bit set; R10 same cycle
    for (int c = 0; c < 16; c++) begin
      apply(4'(c));
      chk("R1 bcd gray full", q0, gray(4'(c)));
      chk("R6 bcd gray fixed", q1, gray(4'(c)));
    end

    // R5: one term (A) shared by all outputs; old function held until commit
    clear_tbl(); tp[0] = 4'h8; tor[0] = 4'hF; build(0); send(0);
    apply(4'h5);
    chk("R7 old function held", q0, gray(4'h5));
    din = 4'h9;
    commit(0);
    @(negedge clk);
    chk("R8 new function after commit", q0, 4'hF);
    for (int c = 0; c < 16; c++) begin
      apply(4'(c));
      chk("R5 shared term", q0, {4{c[3]}});
    end

    // R3: A and A' in one term
    clear_tbl(); tp[0] = 4'h8; tn[0] = 4'h8; tor[0] = 4'hF; build(0); send(0); commit(0);
    for (int c = 0; c < 16; c++) begin
      apply(4'(c));
      chk("R3 contradictory term", q0, 4'h0);
    end

    // R4: term with no literal but all OR bits set
    clear_tbl(); tor[3] = 4'hF; build(0); send(0); commit(0);
    for (int c = 0; c < 16; c++) begin
      apply(4'(c));
      chk("R4 empty term", q0, 4'h0);
    end

    // R2: term 2 uses complement of in_vec[2] (literal 5) and feeds output 0
    clear_tbl(); tn[2] = 4'h4; tor[2] = 4'h1; build(0); send(0); commit(0);
    for (int c = 0; c < 16; c++) begin
      apply(4'(c));
      chk("R2 literal position", q0, {3'b000, ~c[2]});
    end

    // R9: reset from a programmed state
    bcd_tbl(1); build(1); send(1); commit(1);
    do_reset();
    for (int c = 0; c < 16; c++) begin
      apply(4'(c));
      chk("R9 reset uut", q0, 4'h0);
      chk("R9 reset uut_fix", q1, 4'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule